// File: doc/BRIEF.md
# Writeback-Stage Exception Commit Unit

This block is the control skeleton of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that defers every exception to the writeback stage. Each stage holds a valid flag, the instruction address and an optional fault cause. A stage that detects a fault tags the instruction as it moves on. The tag then travels down the pipe with the instruction. No trap is taken before the instruction is the oldest in flight.

When a tagged instruction sits in writeback, the unit takes the exception in that cycle. It suppresses the register-file write and invalidates every younger instruction in earlier stages. It loads the fetch PC with a handler address formed from a software-loadable table base and the cause number. It also records the faulting address and cause in dedicated registers. Taken branches and jumps resolved in decode redirect fetch through a separate, lower-priority path. The datapath, forwarding and the handler table memory are not part of the block.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset the fetch PC equals the BOOT_PC parameter (default 0), all stages are invalid, and the table base, fault address and fault cause registers are zero.
- R2: Instructions advance one stage per clock with no stalls; `stage_valid_o` bit 0 is fetch, 1 decode, 2 execute, 3 memory and 4 writeback. A valid unfaulted instruction in writeback raises `commit_o` with its address on `commit_pc_o`.
- R3: A valid faulted instruction in writeback raises `exc_take_o` in that cycle and keeps `commit_o` low.
- R4: In the cycle after an exception is taken, all five stages are invalid, so no younger instruction ever commits.
- R5: On an exception the fetch PC becomes table base + cause × 4.
- R6: On an exception, `epc_o` takes the faulting instruction's address and `ecause_o` its cause; both hold their values at all other times.
- R7: The table base is loaded from `tbase_data_i` when `tbase_we_i` is high. A load in the same cycle as an exception affects only later handler addresses.
- R8: A fault input for stage k (bit k of `flt_i`, cause in bits k×CAUSE_W upward of `cause_i`, k = 0 fetch to 3 memory) tags the instruction in that stage. If it is already tagged, the earlier cause is kept.
- R9: Fault inputs for a stage holding no valid instruction have no effect.
- R10: A decode redirect (`br_redirect_i` with decode valid) loads the fetch PC with `br_target_i`. It also invalidates the instruction in fetch and the one being fetched.
- R11: A decode redirect in the same cycle as an exception is ignored.
- R12: With no redirect, the fetch PC advances by 4 when `fetch_valid_i` is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | Instruction at `pc_o` is fetched this cycle |
| flt_i | input | 4 | Fault detected in stage k (0 fetch .. 3 memory) |
| cause_i | input | 4×CAUSE_W | Cause number per stage, stage k in slice k |
| br_redirect_i | input | 1 | Decode-stage branch or jump redirect |
| br_target_i | input | XLEN | Redirect target |
| tbase_we_i | input | 1 | Load handler table base |
| tbase_data_i | input | XLEN | New table base |
| pc_o | output | XLEN | Fetch PC |
| stage_valid_o | output | 5 | Valid flag per stage |
| commit_o | output | 1 | Writeback instruction commits (register write enable) |
| commit_pc_o | output | XLEN | Address of the writeback instruction |
| exc_take_o | output | 1 | Exception taken this cycle |
| epc_o | output | XLEN | Faulting instruction address |
| ecause_o | output | CAUSE_W | Fault cause |

## Verification
Directed sequences cover a single instruction faulting in execute with the default base. This separates the cause-times-four handler arithmetic from ordinary PC advance. A doubly faulted instruction in a busy pipe meets a same-cycle branch and base write, which tells earliest-cause retention, branch priority and old-base use apart. A lone decode redirect and faults aimed at empty stages isolate squash scope and the rule that invalid slots never fault. Long random runs with sparse faults, branches and base loads are compared every cycle against a bench model of the requirements. These runs reach back-to-back flushes and redirects that follow one another closely.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int NST  = 5;
   localparam int NDET = NST - 1;
   typedef enum int {ST_FETCH = 0, ST_DECODE = 1, ST_EXEC = 2, ST_MEM = 3, ST_WB = 4} stage_e;
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kill_i,
   input  logic               src_valid_i,
   input  logic               src_fault_i,
   input  logic [CAUSE_W-1:0] src_cause_i,
   input  logic [XLEN-1:0]    src_pc_i,
   input  logic               det_i,
   input  logic [CAUSE_W-1:0] det_cause_i,
   output logic               valid_o,
   output logic               fault_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [XLEN-1:0]    pc_o
);
   logic               nxt_valid, nxt_fault;
   logic [CAUSE_W-1:0] nxt_cause;

   always_comb begin
      nxt_valid = src_valid_i & ~kill_i;
      nxt_fault = nxt_valid & (src_fault_i | det_i);
      nxt_cause = src_fault_i ? src_cause_i : det_cause_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         fault_o <= 1'b0;
         cause_o <= '0;
         pc_o    <= '0;
      end else begin
         valid_o <= nxt_valid;
         fault_o <= nxt_fault;
         cause_o <= nxt_fault ? nxt_cause : '0;
         pc_o    <= src_pc_i;
      end
   end

   // R9
   invalid_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> !fault_o);

   // R8
   cause_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid_i && src_fault_i && !kill_i) |=> (fault_o && cause_o == $past(src_cause_i)));
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc #(
   parameter int XLEN        = 32,
   parameter int CAUSE_W     = 5,
   parameter int ENTRY_SHIFT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [XLEN-1:0]    data_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic [XLEN-1:0]    handler_o
);
   localparam int OFS_W = CAUSE_W + ENTRY_SHIFT;

   logic [XLEN-1:0] base_q;
   logic [OFS_W-1:0] ofs;

   generate
      if (OFS_W > XLEN) begin : g_bad_width
         $error("cause offset wider than address");
      end
      if (ENTRY_SHIFT == 0) begin : g_packed
         assign ofs = cause_i;
      end else begin : g_spaced
         assign ofs = {cause_i, {ENTRY_SHIFT{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    base_q <= '0;
      else if (we_i) base_q <= data_i;
   end

   assign handler_o = base_q + XLEN'(ofs);

   // R7
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(base_q));
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit import exc_pkg::*; #(
   parameter int XLEN        = 32,
   parameter int CAUSE_W     = 5,
   parameter int ENTRY_SHIFT = 2,
   parameter int ILEN_BYTES  = 4,
   parameter logic [XLEN-1:0] BOOT_PC = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fetch_valid_i,
   input  logic [NDET-1:0]         flt_i,
   input  logic [NDET*CAUSE_W-1:0] cause_i,
   input  logic                    br_redirect_i,
   input  logic [XLEN-1:0]         br_target_i,
   input  logic                    tbase_we_i,
   input  logic [XLEN-1:0]         tbase_data_i,
   output logic [XLEN-1:0]         pc_o,
   output logic [NST-1:0]          stage_valid_o,
   output logic                    commit_o,
   output logic [XLEN-1:0]         commit_pc_o,
   output logic                    exc_take_o,
   output logic [XLEN-1:0]         epc_o,
   output logic [CAUSE_W-1:0]      ecause_o
);
   localparam int WB = NST - 1;

   generate
      if (XLEN < 8 || CAUSE_W < 1 || ILEN_BYTES < 1) begin : g_bad_param
         $error("illegal parameter set");
      end
   endgenerate

   logic [NST-1:0]              sv, sf;
   logic [NST-1:0][CAUSE_W-1:0] sc;
   logic [NST-1:0][XLEN-1:0]    sp;
   logic                        take, br_take;
   logic [XLEN-1:0]             handler, pc_q;

   assign take    = sv[WB] & sf[WB];
   assign br_take = br_redirect_i & sv[ST_DECODE] & ~take;

   generate
      for (genvar k = 0; k < NST; k++) begin : g_stage
         if (k == 0) begin : g_head
            exc_stage_reg #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_reg (
               .clk(clk), .rst_n(rst_n), .kill_i(take | br_take),
               .src_valid_i(fetch_valid_i), .src_fault_i(1'b0), .src_cause_i('0),
               .src_pc_i(pc_q), .det_i(1'b0), .det_cause_i('0),
               .valid_o(sv[k]), .fault_o(sf[k]), .cause_o(sc[k]), .pc_o(sp[k]));
         end else begin : g_body
            exc_stage_reg #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_reg (
               .clk(clk), .rst_n(rst_n),
               .kill_i(take | ((k == ST_DECODE) & br_take)),
               .src_valid_i(sv[k-1]), .src_fault_i(sf[k-1]), .src_cause_i(sc[k-1]),
               .src_pc_i(sp[k-1]), .det_i(flt_i[k-1]),
               .det_cause_i(cause_i[(k-1)*CAUSE_W +: CAUSE_W]),
               .valid_o(sv[k]), .fault_o(sf[k]), .cause_o(sc[k]), .pc_o(sp[k]));
         end
      end
   endgenerate

   exc_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_vec (
      .clk(clk), .rst_n(rst_n), .we_i(tbase_we_i), .data_i(tbase_data_i),
      .cause_i(sc[WB]), .handler_o(handler));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= BOOT_PC;
         epc_o    <= '0;
         ecause_o <= '0;
      end else begin
         if (take)               pc_q <= handler;
         else if (br_take)       pc_q <= br_target_i;
         else if (fetch_valid_i) pc_q <= pc_q + XLEN'(ILEN_BYTES);
         if (take) begin
            epc_o    <= sp[WB];
            ecause_o <= sc[WB];
         end
      end
   end

   assign pc_o          = pc_q;
   assign stage_valid_o = sv;
   assign commit_o      = sv[WB] & ~sf[WB];
   assign commit_pc_o   = sp[WB];
   assign exc_take_o    = take;

   // R3
   no_commit_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take_o |-> !commit_o);

   // R4
   flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take_o |=> (stage_valid_o == '0));

   // R6
   epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take_o |=> (epc_o == $past(commit_pc_o)));

   // R6
   epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_take_o |=> ($stable(epc_o) && $stable(ecause_o)));

   // R10
   redirect_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_take |=> (!stage_valid_o[ST_FETCH] && !stage_valid_o[ST_DECODE] && pc_o == $past(br_target_i)));

   // R12
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_i && !exc_take_o && !br_take) |=> (pc_o == $past(pc_o) + XLEN'(ILEN_BYTES)));
endmodule

// File: tb/exc_commit_unit_test.sv
module exc_commit_unit_test;
   localparam int XL = 32;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fv = 1'b0;
   logic [3:0]    flt = '0;
   logic [4*CW-1:0] cz = '0;
   logic          br = 1'b0;
   logic [XL-1:0] tgt = '0;
   logic          we = 1'b0;
   logic [XL-1:0] wd = '0;
   logic [XL-1:0] pc, cpc, epc;
   logic [4:0]    sv;
   logic          commit, take;
   logic [CW-1:0] ecause;

   int compared = 0;
   int mismatched = 0;

   exc_commit_unit uut (
      .clk(clk), .rst_n(rst_n), .fetch_valid_i(fv), .flt_i(flt), .cause_i(cz),
      .br_redirect_i(br), .br_target_i(tgt), .tbase_we_i(we), .tbase_data_i(wd),
      .pc_o(pc), .stage_valid_o(sv), .commit_o(commit), .commit_pc_o(cpc),
      .exc_take_o(take), .epc_o(epc), .ecause_o(ecause));

   always #2 clk = ~clk;

   // reference model state, built from the requirements
   logic          mv[5], mf[5];
   logic [CW-1:0] mc[5];
   logic [XL-1:0] mp[5];
   logic [XL-1:0] mpc, mbase, mepc;
   logic [CW-1:0] mcause;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 5; k++) begin mv[k] = 0; mf[k] = 0; mc[k] = 0; mp[k] = 0; end
         mpc = 0; mbase = 0; mepc = 0; mcause = 0;
      end else begin
         logic tk, bt;
         logic [XL-1:0] hnd;
         tk  = mv[4] & mf[4];
         bt  = br & mv[1] & ~tk;
         hnd = mbase + {22'd0, mc[4], 2'b00};
         if (tk) begin mepc = mp[4]; mcause = mc[4]; end
         for (int k = 4; k >= 1; k--) begin
            logic nvv;
            nvv   = mv[k-1] & ~tk & ~(bt && k == 1);
            mc[k] = mf[k-1] ? mc[k-1] : cz[(k-1)*CW +: CW];
            mf[k] = nvv & (mf[k-1] | flt[k-1]);
            if (!mf[k]) mc[k] = 0;
            mv[k] = nvv;
            mp[k] = mp[k-1];
         end
         mv[0] = fv & ~tk & ~bt; mf[0] = 0; mc[0] = 0; mp[0] = mpc;
         if (tk) mpc = hnd;
         else if (bt) mpc = tgt;
         else if (fv) mpc = mpc + 4;
         if (we) mbase = wd;
      end
   end

   task automatic chk(string tag, logic [XL-1:0] got, logic [XL-1:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cmp_all();
      chk("R12 pc", pc, mpc);
      chk("R2 stage valid", 32'(sv), 32'({mv[4], mv[3], mv[2], mv[1], mv[0]}));
      chk("R2 commit", 32'(commit), 32'(mv[4] & ~mf[4]));
      if (mv[4]) chk("R2 commit pc", cpc, mp[4]);
      chk("R3 take", 32'(take), 32'(mv[4] & mf[4]));
      chk("R6 epc", epc, mepc);
      chk("R6 cause", 32'(ecause), 32'(mcause));
   endtask

   task automatic cyc(logic f, logic [3:0] fl, logic [4*CW-1:0] c, logic b,
                      logic [XL-1:0] t, logic w, logic [XL-1:0] d);
      fv = f; flt = fl; cz = c; br = b; tgt = t; we = w; wd = d;
      @(negedge clk);
      cmp_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 pc", pc, 0);
      chk("R1 valid", 32'(sv), 0);
      chk("R1 epc", epc, 0);
      chk("R1 cause", 32'(ecause), 0);

      // illegal opcode cause 6 found in execute, default base
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R12 pc step", pc, 4);
      cyc(0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk("R2 in execute", 32'(sv), 32'b00100);
      cyc(0, 4'b0100, 20'(6) << (2*CW), 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk("R3 take", 32'(take), 1);
      chk("R3 no commit", 32'(commit), 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk("R5 R7 handler default base", pc, 24);
      chk("R6 epc", epc, 0);
      chk("R6 cause", 32'(ecause), 6);

      // R9 faults on empty stages do nothing
      cyc(0, 4'hF, {4{5'd7}}, 0, 0, 0, 0);
      cyc(0, 4'hF, {4{5'd7}}, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) begin
         cyc(0, 0, 0, 0, 0, 0, 0);
         chk("R9 no trap from empty slots", 32'(take), 0);
      end

      // double fault, base written, branch in the same cycle as trap
      cyc(0, 0, 0, 0, 0, 1, 32'h100);
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(1, 4'b0001, 20'(3), 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(1, 4'b1000, 20'(9) << (3*CW), 0, 0, 0, 0);
      chk("R3 second take", 32'(take), 1);
      cyc(1, 0, 0, 1, 32'h800, 1, 32'h200);
      chk("R8 R11 R7 handler", pc, 32'h10C);
      chk("R8 earliest cause", 32'(ecause), 3);
      chk("R6 epc", epc, 24);
      chk("R4 flush", 32'(sv), 0);

      // R10 lone decode redirect
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 1, 32'h400, 0, 0);
      chk("R10 target", pc, 32'h400);
      chk("R10 squash", 32'(sv), 32'b00100);

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] fl;
         for (int k = 0; k < 4; k++) fl[k] = ($urandom_range(0, 15) == 0);
         cyc($urandom_range(0, 3) != 0, fl, 20'($urandom),
             $urandom_range(0, 5) == 0, $urandom & 32'hFFFF_FFFC,
             $urandom_range(0, 19) == 0, $urandom & 32'hFFFF_FF00);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule